// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block multiplies two 32-bit operands and combines the 64-bit product with an accumulator split into a HI half and a LO half. One operation may be issued per cycle with a valid strobe and a 4-bit operation code. The unit can leave the product as it is, negate it, add it to the accumulator or subtract it from the accumulator. Each of these four kinds exists in a signed and an unsigned flavour.

The 64-bit result is always written back into HI and LO. A destination value is returned one cycle later, together with a done pulse. The code also chooses whether that value is the new LO or the new HI. A core's integer pipeline would use the block as its multiply unit. The destination value goes to the register file, and HI/LO stay visible for later accumulation.

The operation code has three fields. Bit 0 selects unsigned operands when set. Bit 1 selects the new HI as the destination value when set, and the new LO when clear. Bits [3:2] select the kind of operation: 00 is plain product, 01 is negated product, 10 is accumulate and 11 is deduct. All 16 codes are legal.

Top module: `mac_hilo`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears HI, LO and the destination value to zero and holds done low.
- R2: With code bit 0 clear, both operands are signed two's-complement values. With bit 0 set, both are unsigned. The product is the full 64-bit product under that interpretation.
- R3: Kind 00 (bits [3:2]) produces the product alone, and the previous accumulator contents have no effect on it.
- R4: Kind 01 produces the two's-complement negation of the product modulo 2^64, and the previous accumulator contents have no effect on it.
- R5: Kind 10 produces {HI,LO} plus the product modulo 2^64.
- R6: Kind 11 produces {HI,LO} minus the product modulo 2^64.
- R7: In the cycle after a valid operation, LO holds result bits [31:0] and HI holds result bits [63:32].
- R8: In the cycle after a valid operation, the destination value equals the new LO when code bit 1 is 0, and the new HI when code bit 1 is 1.
- R9: done is high for exactly the cycle that follows each valid operation. Without valid, HI, LO and the destination value hold, and operands and code are ignored.
- R10: Additions and subtractions wrap silently, with no flag and no saturation. For example, an accumulator of zero minus 1*1 gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation code: bit 0 unsigned, bit 1 return HI, bits [3:2] kind |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| dest_val | output | 32 | Registered destination value (new LO or new HI) |
| done | output | 1 | One-cycle pulse marking a fresh dest_val |
| hi_q | output | 32 | Accumulator upper half |
| lo_q | output | 32 | Accumulator lower half |

## Verification
The only state in the block is HI, LO, the destination register and done, and all four are visible at the ports. A corrupted accumulator therefore shows on hi_q and lo_q in the cycle after the operation that caused it. The accumulate and deduct kinds also carry the error forward, so every later result stays off the bench model until a plain or negated product overwrites the accumulator. A wrong field decode shows within one cycle as a mismatch between dest_val and the expected half, or as a wrong sign in the product.

// File: rtl/mac_hilo.sv
module mac_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] dest_val,
  output logic         done,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  localparam int AW = 2 * W;

  logic          is_signed;
  logic          want_hi;
  logic [1:0]    kind;
  logic [AW-1:0] ext_a, ext_b, prod, acc, res;

  assign is_signed = ~op_code[0];
  assign want_hi   = op_code[1];
  assign kind      = op_code[3:2];

  assign ext_a = {{W{is_signed & src_a[W-1]}}, src_a};
  assign ext_b = {{W{is_signed & src_b[W-1]}}, src_b};
  assign prod  = ext_a * ext_b;
  assign acc   = {hi_q, lo_q};

  always_comb begin
    unique case (kind)
      2'b00:   res = prod;
      2'b01:   res = '0 - prod;
      2'b10:   res = acc + prod;
      default: res = acc - prod;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      dest_val <= '0;
      done     <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        hi_q     <= res[AW-1:W];
        lo_q     <= res[W-1:0];
        dest_val <= want_hi ? res[AW-1:W] : res[W-1:0];
      end
    end
  end
endmodule

module mac_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [W-1:0] dest_val,
  input logic         done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (hi_q == '0 && lo_q == '0 && dest_val == '0 && !done)); // R1
  AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (rst) op_valid |=> done); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !op_valid |=> (!done && $stable(hi_q) && $stable(lo_q) && $stable(dest_val))); // R9
  AST_DEST_IS_HI: assert property (@(posedge clk) disable iff (rst) (op_valid && op_code[1]) |=> dest_val == hi_q); // R8
  AST_DEST_IS_LO: assert property (@(posedge clk) disable iff (rst) (op_valid && !op_code[1]) |=> dest_val == lo_q); // R8
  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst) (op_valid && !op_code[3] && (src_a == '0 || src_b == '0)) |=> (hi_q == '0 && lo_q == '0)); // R3
endmodule

bind mac_hilo mac_hilo_chk #(.W(W)) u_mac_hilo_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .src_a(src_a), .src_b(src_b), .dest_val(dest_val), .done(done),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_mac_hilo.sv
module test_mac_hilo;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] dest_val, hi_q, lo_q;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_acc = '0;
  logic [31:0] m_dest = '0;

  always #(PERIOD/2) clk = ~clk;

  mac_hilo i_mac_hilo (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .dest_val(dest_val), .done(done),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [3:0] c, logic [31:0] a, logic [31:0] b, logic [63:0] acc);
    logic [63:0] p;
    if (c[0]) p = {32'b0, a} * {32'b0, b};
    else      p = 64'($signed(a)) * 64'($signed(b));
    case (c[3:2])
      2'd0: return p;
      2'd1: return -p;
      2'd2: return acc + p;
      default: return acc - p;
    endcase
  endfunction

  task automatic run_op(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    logic [63:0] r;
    string tag;
    r = model(c, a, b, m_acc);
    case (c[3:2])
      2'd0: tag = "R3 R2 R7";
      2'd1: tag = "R4 R2 R7";
      2'd2: tag = "R5 R2 R7";
      default: tag = "R6 R2 R7";
    endcase
    op_valid = 1'b1; op_code = c; src_a = a; src_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    m_acc  = r;
    m_dest = c[1] ? r[63:32] : r[31:0];
    check64(tag, {hi_q, lo_q}, m_acc);
    check64("R8", {32'b0, dest_val}, {32'b0, m_dest});
    check64("R9 done", {63'b0, done}, 64'd1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFFFFFF; vals[3] = 32'h80000000;
    vals[4] = 32'h7FFFFFFF; vals[5] = 32'h12345678; vals[6] = 32'hDEADBEEF; vals[7] = 32'h00010003;

    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check64("R1 hilo", {hi_q, lo_q}, 64'd0);
    check64("R1 dest", {32'b0, dest_val}, 64'd0);
    check64("R1 done", {63'b0, done}, 64'd0);

    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(4'(c), vals[i], vals[j]);

    // R10: wrap below zero
    run_op(4'b0000, 32'd0, 32'd5);
    run_op(4'b1100, 32'd1, 32'd1);
    check64("R10 wrap", {hi_q, lo_q}, 64'hFFFFFFFFFFFFFFFF);
    run_op(4'b1001, 32'd1, 32'd1);
    check64("R10 wrap up", {hi_q, lo_q}, 64'd0);

    // R9: idle cycles ignore inputs
    run_op(4'b1010, 32'h00001234, 32'h00005678);
    for (int k = 0; k < 4; k++) begin
      op_code = 4'(k * 5); src_a = 32'hA5A5A5A5 + 32'(k); src_b = 32'h5A5A5A5A;
      @(negedge clk);
      check64("R9 hold hilo", {hi_q, lo_q}, m_acc);
      check64("R9 hold dest", {32'b0, dest_val}, {32'b0, m_dest});
      check64("R9 idle done", {63'b0, done}, 64'd0);
    end

    // pseudo-random back-to-back sweep
    begin
      logic [31:0] x = 32'h1ACE5EED;
      for (int n = 0; n < 2000; n++) begin
        logic [31:0] a, b;
        x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]}; a = x;
        x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]}; b = x * 32'h9E3779B9;
        run_op(a[3:0] ^ b[7:4], a, b);
      end
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_acc = '0; m_dest = '0;
    check64("R1 mid hilo", {hi_q, lo_q}, 64'd0);
    check64("R1 mid dest", {32'b0, dest_val}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule